// File: doc/BRIEF.md
# Periodic Memory CRC Error Detector

This block watches a configuration-style memory for upsets while the chip runs. When the start strobe marks entry to user mode, it begins reading the memory through a synchronous read port. It reads one 32-bit word per enabled cycle, in ascending address order. Each word is folded into a running CRC-32. When the last word of a pass has been absorbed, the result is compared against a precomputed reference held in a 32-bit storage register. Scanning then starts again with the next pass, and it repeats until reset.

The comparison result is kept in a 32-bit signature register. It is all zeros when the memory matches the reference. The error output is high whenever that register is non-zero, so it always describes the most recent completed pass and holds that value throughout the pass that follows.

The reference is loaded once when configuration finishes. A serial shift path can later overwrite it, one bit per clock, while scanning carries on. This lets a deliberately wrong reference prove that the checker itself works. A power-of-two divider sets the scan rate.

Top module: `mem_crc_scrubber`

## Requirements
- R1: The storage register takes `ref_load_data` on a cycle where `ref_load` is high. A load has priority over a shift issued in the same cycle.
- R2: No read is issued before the first `user_mode_start` pulse. From that pulse onward, `mem_rd_en` pulses read addresses 0, 1, …, WORDS-1 in order and then wrap to 0, with no end until reset. Read data is taken exactly one clock after the enabled read cycle.
- R3: A pass CRC starts from all ones. Each word is XORed into the CRC, and the CRC is then shifted right 32 times, with 0xEDB88320 XORed in whenever the bit shifted out is 1. The final value is inverted.
- R4: At the end of a pass, the signature register takes the pass CRC XOR the storage register. `crc_error` is high exactly when the signature is non-zero. It changes on the second rising edge after the cycle in which the last address was issued.
- R5: `crc_error` changes only at pass completions, so a fault stays flagged through the whole next pass. A pass that completes clean drives it low, whatever earlier passes found.
- R6: When `inj_shift_en` is high and `ref_load` is low, the storage register becomes {`inj_shift_din`, storage[31:1]}. Thirty-two shifts therefore replace it, bit 0 first. Reads continue during shifting, and the end-of-pass comparison uses the storage value present at that moment.
- R7: Reads are spaced 2^n clocks apart, where n is `div_sel`. Values above 8 are treated as 8.
- R8: `div_sel` is sampled only at the start pulse and at the cycle the last address of a pass is issued. A change in mid-pass leaves the remaining reads of that pass at the old spacing.
- R9: During and right after reset, `crc_error` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| user_mode_start | input | 1 | One-cycle pulse that starts continuous scanning |
| ref_load | input | 1 | Load strobe for the reference signature |
| ref_load_data | input | 32 | Precomputed reference signature |
| inj_shift_en | input | 1 | Shift the storage register one bit this cycle |
| inj_shift_din | input | 1 | Serial bit entering the storage register at bit 31 |
| div_sel | input | 4 | Rate exponent n; reads every 2^n clocks |
| mem_rd_en | output | 1 | Read request to the memory |
| mem_rd_addr | output | $clog2(WORDS) | Read address |
| mem_rd_data | input | 32 | Read data, valid one clock after the request |
| crc_error | output | 1 | High when the last completed pass mismatched |

## Verification
The case hardest to reach from the ports is a reference changed by the shift path while a pass is already under way. That change must show up in exactly that pass's verdict, and on the exact edge predicted. The bench watches the read port for the last-address read, which marks each pass boundary. Right after a boundary it shifts a flipped or restored reference in at a slow rate. It then checks `crc_error` one cycle before and one cycle after the predicted update edge. A mid-pass change of the rate select is reached the same way: the bench keys on a known mid-pass address and then measures the gaps between reads.

// File: rtl/crc_scrub_pkg.sv
// Package: shared constants and the word-wide CRC step for the scrubber.
// Assumes 32-bit memory words and the reflected CRC-32 polynomial.
package crc_scrub_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    // Fold one 32-bit word into the CRC, least significant bit first.
    function automatic logic [31:0] crc32_word(input logic [31:0] crc_in,
                                               input logic [31:0] word);
        logic [31:0] r;
        r = crc_in ^ word;
        for (int i = 0; i < 32; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/scrub_rate_div.sv
// Rate divider: emits one tick every 2^rate_q clocks while running.
// Assumes load_rate pulses only at the start or at a pass boundary.
module scrub_rate_div #(
    parameter int MAX_SHIFT = 8,
    parameter int SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load_rate,
    input  logic [SEL_W-1:0] rate_in,
    output logic             tick,
    output logic [SEL_W-1:0] rate_q
);
    localparam int CNT_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span_m1;
    logic [SEL_W-1:0] rate_clamped;

    // Limit the requested exponent to the supported range.
    always_comb begin
        rate_clamped = (rate_in > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : rate_in;
    end

    // Derive the terminal count 2^rate_q - 1 from the latched exponent.
    always_comb begin
        span_m1 = ((CNT_W + 1)'(1) << rate_q) - (CNT_W + 1)'(1);
    end

    assign tick = run && (cnt_q == span_m1[CNT_W-1:0]);

    // Hold the exponent in use; change it only when told to.
    always_ff @(posedge clk) begin
        if (!rst_n)         rate_q <= '0;
        else if (load_rate) rate_q <= rate_clamped;
    end

    // Count clocks between ticks, restarting after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/scrub_addr_seq.sv
// Address sequencer: walks 0..WORDS-1 on each tick, then wraps.
// Assumes WORDS is at least 2.
module scrub_addr_seq #(
    parameter int WORDS = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          last_issue
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(WORDS - 1);

    assign rd_en      = tick;
    assign last_issue = tick && (rd_addr == LAST_ADDR);

    // Advance the address after every issued read.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_addr <= '0;
        else if (last_issue) rd_addr <= '0;
        else if (tick)       rd_addr <= rd_addr + 1'b1;
    end
endmodule

// File: rtl/scrub_crc_engine.sv
// CRC engine: absorbs one word per valid cycle and presents the final,
// inverted CRC in the same cycle as the last word. Restarts from all ones.
module scrub_crc_engine
    import crc_scrub_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_vld,
    input  logic        word_last,
    input  logic [31:0] word,
    output logic        pass_done,
    output logic [31:0] pass_crc
);
    logic [31:0] crc_q;
    logic [31:0] crc_next;

    // Combine the incoming word with the running value.
    always_comb begin
        crc_next = crc32_word(crc_q, word);
    end

    assign pass_done = word_vld && word_last;
    assign pass_crc  = ~crc_next;

    // Keep the running CRC; reseed it at the end of each pass.
    always_ff @(posedge clk) begin
        if (!rst_n)         crc_q <= CRC_INIT;
        else if (pass_done) crc_q <= CRC_INIT;
        else if (word_vld)  crc_q <= crc_next;
    end
endmodule

// File: rtl/mem_crc_scrubber.sv
// Top: periodic CRC scrubber for a memory behind a synchronous read port.
// Assumes the memory returns data one clock after mem_rd_en.
module mem_crc_scrubber
    import crc_scrub_pkg::*;
#(
    parameter  int WORDS          = 16,
    parameter  int MAX_RATE_SHIFT = 8,
    localparam int AW             = (WORDS > 2) ? $clog2(WORDS) : 1,
    localparam int SEL_W          = $clog2(MAX_RATE_SHIFT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             user_mode_start,
    input  logic             ref_load,
    input  logic [31:0]      ref_load_data,
    input  logic             inj_shift_en,
    input  logic             inj_shift_din,
    input  logic [SEL_W-1:0] div_sel,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [31:0]      mem_rd_data,
    output logic             crc_error
);
    logic             run_q;
    logic             start_now;
    logic             tick;
    logic [SEL_W-1:0] rate_q;
    logic             last_issue;
    logic             data_vld_q;
    logic             last_vld_q;
    logic             pass_done;
    logic [31:0]      pass_crc;
    logic [31:0]      storage_q;
    logic [31:0]      signature_q;

    assign start_now = user_mode_start && !run_q;

    // Enter the running state on the first start pulse; leave only on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= 1'b0;
        else if (start_now) run_q <= 1'b1;
    end

    scrub_rate_div #(.MAX_SHIFT(MAX_RATE_SHIFT), .SEL_W(SEL_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .load_rate (start_now || last_issue),
        .rate_in   (div_sel),
        .tick      (tick),
        .rate_q    (rate_q)
    );

    scrub_addr_seq #(.WORDS(WORDS), .AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rd_en      (mem_rd_en),
        .rd_addr    (mem_rd_addr),
        .last_issue (last_issue)
    );

    // Mark which clock carries returned read data and the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_vld_q <= 1'b0;
            last_vld_q <= 1'b0;
        end else begin
            data_vld_q <= mem_rd_en;
            last_vld_q <= last_issue;
        end
    end

    scrub_crc_engine u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld  (data_vld_q),
        .word_last (last_vld_q),
        .word      (mem_rd_data),
        .pass_done (pass_done),
        .pass_crc  (pass_crc)
    );

    // Reference storage: parallel load wins over the serial shift path.
    always_ff @(posedge clk) begin
        if (!rst_n)            storage_q <= '0;
        else if (ref_load)     storage_q <= ref_load_data;
        else if (inj_shift_en) storage_q <= {inj_shift_din, storage_q[31:1]};
    end

    // Latch the comparison once per completed pass.
    always_ff @(posedge clk) begin
        if (!rst_n)         signature_q <= '0;
        else if (pass_done) signature_q <= pass_crc ^ storage_q;
    end

    assign crc_error = |signature_q;
endmodule

// File: rtl/scrub_checker.sv
// Checker: protocol and timing properties of the scrubber, attached by bind.
module scrub_checker #(
    parameter int WORDS = 16,
    parameter int AW    = 4,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_q,
    input logic             mem_rd_en,
    input logic [AW-1:0]    mem_rd_addr,
    input logic             last_vld_q,
    input logic             crc_error,
    input logic             ref_load,
    input logic [31:0]      ref_load_data,
    input logic             inj_shift_en,
    input logic             inj_shift_din,
    input logic [31:0]      storage_q,
    input logic [SEL_W-1:0] rate_q
);
    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !mem_rd_en); // R2
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (32'(mem_rd_addr) < 32'(WORDS))); // R2
    AST_ERR_AT_PASS_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(crc_error) |-> $past(last_vld_q)); // R5
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ref_load |=> (storage_q == $past(ref_load_data))); // R1
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_shift_en && !ref_load) |=>
            (storage_q == {$past(inj_shift_din), $past(storage_q[31:1])})); // R6
    AST_FULL_RATE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (rate_q == '0)); // R7
endmodule

bind mem_crc_scrubber scrub_checker #(.WORDS(WORDS), .AW(AW), .SEL_W(SEL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_q         (run_q),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_addr   (mem_rd_addr),
    .last_vld_q    (last_vld_q),
    .crc_error     (crc_error),
    .ref_load      (ref_load),
    .ref_load_data (ref_load_data),
    .inj_shift_en  (inj_shift_en),
    .inj_shift_din (inj_shift_din),
    .storage_q     (storage_q),
    .rate_q        (rate_q)
);

// File: tb/sim_mem_crc_scrubber.sv
// Bench: sweeps rates, memory patterns, reference loads and serial injection.
module sim_mem_crc_scrubber;
    localparam int WORDS = 16;
    localparam int AW    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        user_mode_start = 1'b0;
    logic        ref_load = 1'b0;
    logic [31:0] ref_load_data = '0;
    logic        inj_shift_en = 1'b0;
    logic        inj_shift_din = 1'b0;
    logic [3:0]  div_sel = '0;
    logic        mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        crc_error;

    logic [31:0] mem [WORDS];
    logic [31:0] ref_model;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    mem_crc_scrubber #(.WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .user_mode_start(user_mode_start),
        .ref_load(ref_load), .ref_load_data(ref_load_data),
        .inj_shift_en(inj_shift_en), .inj_shift_din(inj_shift_din),
        .div_sel(div_sel), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .crc_error(crc_error)
    );

    // Synchronous memory model: data one clock after the request.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            checks++; errors++;
            $display("FAIL watchdog: act %0d cycles exp < 190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] ref_crc();
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int w = 0; w < WORDS; w++) begin
            c = c ^ mem[w];
            for (int b = 0; b < 32; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    task automatic load_ref(input logic [31:0] v);
        @(negedge clk); ref_load = 1'b1; ref_load_data = v;
        @(negedge clk); ref_load = 1'b0;
        ref_model = v;
    endtask

    task automatic shift_ref(input logic [31:0] v);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); inj_shift_en = 1'b1; inj_shift_din = v[i];
        end
        @(negedge clk); inj_shift_en = 1'b0;
        ref_model = v;
    endtask

    // Return at the negedge just before the last-address read is taken.
    task automatic wait_last_issue();
        do @(negedge clk); while (!(mem_rd_en && mem_rd_addr == AW'(WORDS - 1)));
    endtask

    // Return once the verdict of the pass ending next is visible.
    task automatic wait_pass_end();
        wait_last_issue();
        @(negedge clk); @(negedge clk);
    endtask

    task automatic read_gap(output int g);
        g = 0;
        do begin @(negedge clk); g++; end while (!mem_rd_en);
    endtask

    initial begin
        int g;
        int exp_addr;
        int bad;
        for (int w = 0; w < WORDS; w++) mem[w] = 32'h1234_0000 + 32'(w * 7);
        repeat (3) @(negedge clk);
        chk("R9 error in reset", crc_error, 0);
        chk("R9 read in reset", mem_rd_en, 0);
        rst_n = 1'b1;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); if (mem_rd_en) bad++;
        end
        chk("R2 no read before start", bad, 0);
        chk("R9 error after reset", crc_error, 0);

        load_ref(ref_crc());
        chk("R1 reference load", u0.crc_error, 0);
        div_sel = 4'd0;
        @(negedge clk); user_mode_start = 1'b1;
        @(negedge clk); user_mode_start = 1'b0;
        // R2: ascending addresses with wrap, one per clock at rate 0
        while (!mem_rd_en) @(negedge clk);
        bad = 0; exp_addr = 0;
        for (int i = 0; i < 3 * WORDS; i++) begin
            if (!mem_rd_en || int'(mem_rd_addr) != exp_addr) bad++;
            exp_addr = (exp_addr + 1) % WORDS;
            @(negedge clk);
        end
        chk("R2 address order", bad, 0);
        wait_pass_end();
        chk("R3 clean memory", crc_error, 0);

        // R4: a single corrupted bit is flagged
        mem[5] = mem[5] ^ 32'h0000_0100;
        wait_pass_end(); wait_pass_end();
        chk("R4 corrupted word", crc_error, 1);

        // R5: held through the pass in progress, then cleared by a clean pass
        mem[5] = mem[5] ^ 32'h0000_0100;
        bad = 0;
        do begin
            @(negedge clk); if (!crc_error) bad++;
        end while (!(mem_rd_en && mem_rd_addr == AW'(WORDS - 1)));
        @(negedge clk); if (!crc_error) bad++;
        chk("R5 held until pass end", bad, 0);
        wait_pass_end(); wait_pass_end();
        chk("R5 cleared by clean pass", crc_error, 0);

        // R3: several memory patterns, matching and mismatching references
        for (int k = 0; k < 6; k++) begin
            for (int w = 0; w < WORDS; w++)
                mem[w] = (32'(k + 1) * 32'h9E37_79B9) ^ (32'(w) << k) ^ 32'(w * k);
            load_ref(ref_crc());
            wait_pass_end(); wait_pass_end();
            chk("R3 pattern match", crc_error, 0);
            load_ref(ref_crc() ^ (32'h1 << (k * 5)));
            wait_pass_end(); wait_pass_end();
            chk("R1 mismatched reference", crc_error, 1);
        end
        load_ref(ref_crc());
        wait_pass_end(); wait_pass_end();
        chk("R1 reference restored", crc_error, 0);

        // R6: serial injection during a slow pass, verdict on exact edge (R4)
        div_sel = 4'd3;
        wait_pass_end(); wait_pass_end();
        shift_ref(ref_crc() ^ 32'h8000_0000);
        wait_last_issue();
        @(negedge clk);
        chk("R4 verdict not before second edge", crc_error, 0);
        @(negedge clk);
        chk("R6 injected error flagged", crc_error, 1);
        bad = 0;
        shift_ref(ref_crc());
        chk("R6 reads continue while shifting", crc_error, 1);
        wait_pass_end();
        chk("R6 restored reference", crc_error, 0);

        // R8: mid-pass rate change keeps the old spacing until the boundary
        div_sel = 4'd1;
        wait_pass_end(); wait_pass_end();
        do @(negedge clk); while (!(mem_rd_en && mem_rd_addr == AW'(3)));
        div_sel = 4'd4;
        read_gap(g);
        chk("R8 old spacing mid-pass", g, 2);
        wait_last_issue();
        read_gap(g);
        chk("R8 new spacing after boundary", g, 16);

        // R7: spacing sweep including clamped values
        for (int n = 0; n < 10; n++) begin
            div_sel = 4'(n);
            wait_last_issue(); wait_last_issue();
            read_gap(g);
            chk($sformatf("R7 spacing n=%0d", n), g, 1 << ((n > 8) ? 8 : n));
        end
        div_sel = 4'd0;
        wait_pass_end(); wait_pass_end();
        chk("R5 clean after sweep", crc_error, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule